// File: doc/BRIEF.md
# Zero-Overhead Loop Fetch Controller with Replay Buffer

This block owns the fetch address of a processor front end. It runs block-repeat loops with no branch instructions. A loop-start command gives an end address and a repeat count. The loop body begins at the address that follows the fetch in which the command arrives. While no loop is running, the block fetches one instruction per cycle from program memory at linearly increasing addresses.

On the first pass of a loop, every fetched word is also copied into a small replay buffer. When the body fits in that buffer, each later pass is played back from the buffer. The program-memory request is then held low, and the memory address does not move. A body longer than the buffer is fetched from memory on every pass.

Loop contexts are kept on a small stack. When a loop starts while another is active, the outer context is saved. When the inner loop finishes, that context comes back on its own. Explicit context push and pop commands are also provided. Each cycle the block registers the fetched word and its address for the decoder.

Top module: `loop_fetch_ctrl`

## Requirements
- R1: During reset `imem_addr` is 0, and `ir_vld`, `loop_active` and `nest_ovf` are 0. The first fetch after reset is at address 0, and `ir_vld` is 1 from the next cycle on.
- R2: With no loop active, the block fetches from memory (`imem_req`=1) at an address that increases by one each cycle. One cycle after a fetch, `ir_addr` holds that address and `ir_data` holds the word returned for it.
- R3: Suppose `lp_start` is sampled during the fetch of address p. The body is then p+1 through `lp_end`. With `lp_count`=N the body runs N+1 times. After the last pass, fetch continues at `lp_end`+1 and `loop_active` returns to 0.
- R4: Every fetch in the first pass of a loop is a memory read (`imem_req`=1 at the body address).
- R5: The body length is `lp_end`-start+1. If that length is at most BUF_DEPTH, every pass after a complete first pass is played back: `imem_req`=0, and `ir_data` is still the correct word for `ir_addr`.
- R6: A body longer than BUF_DEPTH is read from memory on every pass.
- R7: A loop started while another loop is active saves the outer context. When the inner loop finishes, the outer loop continues at the word after the inner end. Its next pass is read from memory, because the buffer was reused, and later passes are played back.
- R8: `ctx_push` saves the active context and suspends looping: `loop_active`=0 and the address keeps running linearly. `ctx_pop` restores the context and resumes the loop. The refill rule of R7 applies after the restore.
- R9: `ctx_push` with NEST_DEPTH entries stored discards the context and sets `nest_ovf`, which stays 1 until reset. `ctx_pop` with an empty stack is ignored, and a running loop is not disturbed.
- R10: Whenever `imem_req` is 0, `imem_addr` keeps the last address that was read from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_start | input | 1 | Begin a loop after the current fetch |
| lp_end | input | AW | Last address of the loop body |
| lp_count | input | CW | Repeat count N (N+1 passes) |
| ctx_push | input | 1 | Save the loop context and suspend looping |
| ctx_pop | input | 1 | Restore the saved loop context |
| imem_req | output | 1 | Program-memory read enable |
| imem_addr | output | AW | Program-memory address |
| imem_rdata | input | IW | Word read at `imem_addr` in the same cycle |
| ir_data | output | IW | Registered instruction for the decoder |
| ir_addr | output | AW | Address of `ir_data` |
| ir_vld | output | 1 | `ir_data` is valid |
| loop_active | output | 1 | A loop is running |
| nest_ovf | output | 1 | Sticky context-stack overflow |

## Verification
The sweep covers body lengths from one word up to two beyond the buffer size, each with repeat counts from zero to three. The interesting cases are these:
- A one-word body wraps onto itself in its own first cycle. A design that replays too early shows a stale word.
- A design that off-by-ones the fit test either replays a body one word too long, which shows as a wrong `ir_data`, or refetches a body that fits, which shows as `imem_req` left high.
- A design that replays straight after a nested return or a pop shows words left behind by the inner loop instead of the outer body.
- The stack is driven past its depth, and a pop on an empty stack is issued in the middle of a loop. A wrong design loses the overflow flag or ends the loop early.

// File: rtl/loop_fetch_pkg.sv
package loop_fetch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FILL   = 2'd1,
    PH_REPLAY = 2'd2
  } phase_e;
endpackage

// File: rtl/lf_ctx_stack.sv
module lf_ctx_stack #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int PW  = $clog2(DEPTH + 1);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt_q;
  logic          ovf_q;
  logic          full;
  logic [PW-1:0] top_idx;

  assign full    = (cnt_q == PW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = cnt_q - PW'(1);
  assign dout    = mem[top_idx[IXW-1:0]];
  assign ovf     = ovf_q;

  always_ff @(posedge clk) begin
    if (push_i && !full) mem[cnt_q[IXW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i && !full)      cnt_q <= cnt_q + PW'(1);
      else if (pop_i && !empty) cnt_q <= cnt_q - PW'(1);
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= PW'(DEPTH)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && full) |=> (cnt_q == $past(cnt_q)) && ovf_q); // R9
endmodule

// File: rtl/lf_ibuf.sv
module lf_ibuf #(
  parameter int IW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [IW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [IW-1:0]            rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/loop_fetch_ctrl.sv
module loop_fetch_ctrl
  import loop_fetch_pkg::*;
#(
  parameter int AW         = 16,
  parameter int IW         = 32,
  parameter int CW         = 16,
  parameter int BUF_DEPTH  = 16,
  parameter int NEST_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lp_start,
  input  logic [AW-1:0] lp_end,
  input  logic [CW-1:0] lp_count,
  input  logic          ctx_push,
  input  logic          ctx_pop,
  output logic          imem_req,
  output logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_rdata,
  output logic [IW-1:0] ir_data,
  output logic [AW-1:0] ir_addr,
  output logic          ir_vld,
  output logic          loop_active,
  output logic          nest_ovf
);
  localparam int BXW  = $clog2(BUF_DEPTH);
  localparam int CTXW = 1 + 2 * AW + CW;

  phase_e        phase_q, phase_d;
  logic [AW-1:0] pc_q, pc_d, addr_q, addr_d;
  logic [AW-1:0] rsa_q, rsa_d, rea_q, rea_d;
  logic [CW-1:0] brc_q, brc_d;
  logic          clean_q, clean_d;
  logic [IW-1:0] ir_q;
  logic [AW-1:0] ir_pc_q;
  logic          ir_vld_q;

  logic          active, at_end, fits, replay;
  logic [AW-1:0] offs, pc_lin;
  logic [IW-1:0] buf_rd, fetched;
  logic          buf_we;

  logic            ev_pop, ev_push, ev_body;
  logic            stk_push, stk_pop, stk_empty, stk_ovf;
  logic [CTXW-1:0] stk_din, stk_dout;
  logic            sd_act;
  logic [AW-1:0]   sd_rsa, sd_rea;
  logic [CW-1:0]   sd_brc;

  assign active = (phase_q != PH_IDLE);
  assign replay = (phase_q == PH_REPLAY);
  assign at_end = active && (pc_q == rea_q);
  assign offs   = pc_q - rsa_q;
  assign fits   = (rea_q - rsa_q) < AW'(BUF_DEPTH);
  assign pc_lin = pc_q + AW'(1);

  assign buf_we  = (phase_q == PH_FILL) && fits;
  assign fetched = replay ? buf_rd : imem_rdata;

  lf_ibuf #(.IW(IW), .DEPTH(BUF_DEPTH)) u_ibuf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (offs[BXW-1:0]),
    .wdata (imem_rdata),
    .raddr (offs[BXW-1:0]),
    .rdata (buf_rd)
  );

  // command arbitration: start > pop > push > end-of-body
  assign ev_pop  = !lp_start && ctx_pop && !stk_empty;
  assign ev_push = !lp_start && !ev_pop && ctx_push;
  assign ev_body = !lp_start && !ev_pop && !ev_push && at_end;

  assign stk_din  = {active, rsa_q, rea_q, brc_q};
  assign stk_push = (lp_start && active) || ev_push;
  assign stk_pop  = ev_pop || (ev_body && (brc_q == '0) && !stk_empty);
  assign {sd_act, sd_rsa, sd_rea, sd_brc} = stk_dout;

  lf_ctx_stack #(.W(CTXW), .DEPTH(NEST_DEPTH)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .push_i (stk_push),
    .pop_i  (stk_pop),
    .din    (stk_din),
    .dout   (stk_dout),
    .empty  (stk_empty),
    .ovf    (stk_ovf)
  );

  always_comb begin
    phase_d = phase_q;
    pc_d    = pc_lin;
    rsa_d   = rsa_q;
    rea_d   = rea_q;
    brc_d   = brc_q;
    clean_d = clean_q;
    if (lp_start) begin
      rsa_d   = pc_lin;
      rea_d   = lp_end;
      brc_d   = lp_count;
      phase_d = PH_FILL;
      clean_d = 1'b1;
    end else if (ev_pop) begin
      rsa_d   = sd_rsa;
      rea_d   = sd_rea;
      brc_d   = sd_brc;
      phase_d = sd_act ? PH_FILL : PH_IDLE;
      clean_d = 1'b0;
    end else if (ev_push) begin
      phase_d = PH_IDLE;
    end else if (ev_body) begin
      if (brc_q != '0) begin
        brc_d   = brc_q - CW'(1);
        pc_d    = rsa_q;
        phase_d = (clean_q && fits) ? PH_REPLAY : PH_FILL;
        clean_d = 1'b1;
      end else if (!stk_empty) begin
        rsa_d   = sd_rsa;
        rea_d   = sd_rea;
        brc_d   = sd_brc;
        phase_d = sd_act ? PH_FILL : PH_IDLE;
        clean_d = 1'b0;
      end else begin
        phase_d = PH_IDLE;
      end
    end
    addr_d = (phase_d == PH_REPLAY) ? addr_q : pc_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      pc_q     <= '0;
      addr_q   <= '0;
      rsa_q    <= '0;
      rea_q    <= '0;
      brc_q    <= '0;
      clean_q  <= 1'b0;
      ir_q     <= '0;
      ir_pc_q  <= '0;
      ir_vld_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      pc_q     <= pc_d;
      addr_q   <= addr_d;
      rsa_q    <= rsa_d;
      rea_q    <= rea_d;
      brc_q    <= brc_d;
      clean_q  <= clean_d;
      ir_q     <= fetched;
      ir_pc_q  <= pc_q;
      ir_vld_q <= 1'b1;
    end
  end

  assign imem_req    = !replay;
  assign imem_addr   = addr_q;
  assign ir_data     = ir_q;
  assign ir_addr     = ir_pc_q;
  assign ir_vld      = ir_vld_q;
  assign loop_active = active;
  assign nest_ovf    = stk_ovf;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_REPLAY) |-> $stable(addr_q)); // R10
  AST_REPLAY_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_REPLAY && $past(phase_q) != PH_REPLAY) |-> $past(phase_q) == PH_FILL); // R5
  AST_EXIT_AT_END: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && $past(phase_q) != PH_IDLE && !$past(rst)
     && !$past(ctx_push) && !$past(ctx_pop)) |-> $past(pc_q) == $past(rea_q)); // R3
  AST_WRAP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ($past(at_end) && $past(brc_q) != '0 && !$past(rst) && !$past(lp_start)
     && !$past(ctx_push) && !$past(ctx_pop)) |-> pc_q == $past(rsa_q)); // R3
endmodule

// File: tb/loop_fetch_ctrl_test.sv
module loop_fetch_ctrl_test;
  localparam int AW = 10;
  localparam int IW = 16;
  localparam int CW = 4;
  localparam int BUF = 4;
  localparam int NEST = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lp_start = 1'b0;
  logic [AW-1:0] lp_end = '0;
  logic [CW-1:0] lp_count = '0;
  logic          ctx_push = 1'b0;
  logic          ctx_pop = 1'b0;
  logic          imem_req;
  logic [AW-1:0] imem_addr;
  logic [IW-1:0] imem_rdata;
  logic [IW-1:0] ir_data;
  logic [AW-1:0] ir_addr;
  logic          ir_vld;
  logic          loop_active;
  logic          nest_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] word_at(input logic [AW-1:0] a);
    return {a[5:0], a} ^ 16'hA5C3;
  endfunction

  assign imem_rdata = word_at(imem_addr);

  loop_fetch_ctrl #(.AW(AW), .IW(IW), .CW(CW), .BUF_DEPTH(BUF), .NEST_DEPTH(NEST)) uut (
    .clk(clk), .rst(rst), .lp_start(lp_start), .lp_end(lp_end), .lp_count(lp_count),
    .ctx_push(ctx_push), .ctx_pop(ctx_pop), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .ir_data(ir_data), .ir_addr(ir_addr), .ir_vld(ir_vld),
    .loop_active(loop_active), .nest_ovf(nest_ovf)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  logic [AW-1:0] cur;
  logic [AW-1:0] prev_a;
  logic [AW-1:0] last_rd;
  bit have_prev = 0;

  // cmd: 1 start, 2 push, 4 pop. Called at a negedge; checks the fetch of this cycle.
  task automatic step(input logic [AW-1:0] a, input bit req, input bit act,
                      input int cmd, input string tag);
    lp_start = cmd[0];
    ctx_push = cmd[1];
    ctx_pop  = cmd[2];
    chk({tag, " req"}, 32'(imem_req), 32'(req));
    if (req) chk({tag, " addr"}, 32'(imem_addr), 32'(a));
    else     chk("R10 held addr", 32'(imem_addr), 32'(last_rd));
    chk({tag, " active"}, 32'(loop_active), 32'(act));
    if (have_prev) begin
      chk("R2 ir_addr", 32'(ir_addr), 32'(prev_a));
      chk({tag, " ir_data"}, 32'(ir_data), 32'(word_at(prev_a)));
    end
    prev_a = a;
    have_prev = 1;
    if (req) last_rd = a;
    @(posedge clk);
    @(negedge clk);
    lp_start = 1'b0;
    ctx_push = 1'b0;
    ctx_pop  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(cur, 1'b1, 1'b0, 0, "R2 idle");
      cur = cur + AW'(1);
    end
  endtask

  // single loop of len words, count cnt; pop_at>=0 issues a pop (empty stack) at that body offset of pass 0
  task automatic run_loop(input int len, input int cnt, input int pop_at);
    logic [AW-1:0] s;
    s = cur + AW'(1);
    lp_end = s + AW'(len - 1);
    lp_count = CW'(cnt);
    step(cur, 1'b1, 1'b0, 1, "R3 start");
    for (int it = 0; it <= cnt; it++) begin
      for (int k = 0; k < len; k++) begin
        bit rq;
        rq = (it == 0) || (len > BUF);
        step(s + AW'(k), rq, 1'b1, (it == 0 && k == pop_at) ? 4 : 0,
             (it == 0) ? "R4 first pass" : (len > BUF ? "R6 long body" : "R5 replay"));
      end
    end
    cur = lp_end + AW'(1);
    step(cur, 1'b1, 1'b0, 0, "R3 exit");
    cur = cur + AW'(1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset addr", 32'(imem_addr), 0);
    chk("R1 reset ir_vld", 32'(ir_vld), 0);
    chk("R1 reset active", 32'(loop_active), 0);
    chk("R1 reset ovf", 32'(nest_ovf), 0);
    rst = 1'b0;
    cur = '0;
    step(cur, 1'b1, 1'b0, 0, "R1 first fetch");
    cur = cur + AW'(1);
    chk("R1 ir_vld after reset", 32'(ir_vld), 1);
    idle(3);

    // R3 R4 R5 R6 sweep
    for (int len = 1; len <= BUF + 2; len++)
      for (int cnt = 0; cnt <= 3; cnt++)
        run_loop(len, cnt, -1);

    // R7 nested: outer 4 words, count 2; inner starts at first outer word
    begin
      logic [AW-1:0] s1;
      s1 = cur + AW'(1);
      lp_end = s1 + AW'(3);
      lp_count = CW'(2);
      step(cur, 1'b1, 1'b0, 1, "R7 outer start");
      lp_end = s1 + AW'(2);
      lp_count = CW'(1);
      step(s1, 1'b1, 1'b1, 1, "R7 inner start");
      step(s1 + AW'(1), 1'b1, 1'b1, 0, "R7 inner fill");
      step(s1 + AW'(2), 1'b1, 1'b1, 0, "R7 inner fill");
      step(s1 + AW'(1), 1'b0, 1'b1, 0, "R7 inner replay");
      step(s1 + AW'(2), 1'b0, 1'b1, 0, "R7 inner replay");
      step(s1 + AW'(3), 1'b1, 1'b1, 0, "R7 outer resume");
      for (int k = 0; k < 4; k++) step(s1 + AW'(k), 1'b1, 1'b1, 0, "R7 outer refill");
      for (int k = 0; k < 4; k++) step(s1 + AW'(k), 1'b0, 1'b1, 0, "R7 outer replay");
      cur = s1 + AW'(4);
      step(cur, 1'b1, 1'b0, 0, "R7 exit");
      cur = cur + AW'(1);
    end

    // R8 explicit push/pop
    begin
      logic [AW-1:0] s;
      s = cur + AW'(1);
      lp_end = s + AW'(3);
      lp_count = CW'(2);
      step(cur, 1'b1, 1'b0, 1, "R8 start");
      step(s, 1'b1, 1'b1, 2, "R8 push");
      step(s + AW'(1), 1'b1, 1'b0, 4, "R8 suspended");
      step(s + AW'(2), 1'b1, 1'b1, 0, "R8 resumed");
      step(s + AW'(3), 1'b1, 1'b1, 0, "R8 resumed");
      for (int k = 0; k < 4; k++) step(s + AW'(k), 1'b1, 1'b1, 0, "R8 refill");
      for (int k = 0; k < 4; k++) step(s + AW'(k), 1'b0, 1'b1, 0, "R8 replay");
      cur = s + AW'(4);
      step(cur, 1'b1, 1'b0, 0, "R8 exit");
      cur = cur + AW'(1);
    end

    // R9 pop on empty stack inside a loop is ignored
    run_loop(2, 1, 0);
    run_loop(3, 2, 1);

    // R9 overflow
    step(cur, 1'b1, 1'b0, 2, "R9 push1");
    cur = cur + AW'(1);
    chk("R9 ovf after 1 push", 32'(nest_ovf), 0);
    step(cur, 1'b1, 1'b0, 2, "R9 push2");
    cur = cur + AW'(1);
    chk("R9 ovf at full", 32'(nest_ovf), 0);
    step(cur, 1'b1, 1'b0, 2, "R9 push3");
    cur = cur + AW'(1);
    chk("R9 ovf set", 32'(nest_ovf), 1);
    for (int i = 0; i < 3; i++) begin
      step(cur, 1'b1, 1'b0, 4, "R9 pop idle");
      cur = cur + AW'(1);
    end
    chk("R9 ovf sticky", 32'(nest_ovf), 1);
    idle(2);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule